// File: doc/BRIEF.md
# Serial Latch Loader with Deferred Dot-Correction Copy

This block is the serial front end of a multichannel PWM LED driver. A single long shift register takes one bit per serial-clock enable and, on the rising edge of a latch strobe, hands its contents to one of two parallel latches. The top bit of the shift register picks the destination: a 0 sends the lower 768 bits to the grayscale latch (48 channels of 16 bits), a 1 sends the lower 371 bits to the control latch (dot correction, maximum current, brightness and function fields).

The dot-correction values that drive the channels sit in a separate 336-bit working latch fed from the control latch. A refresh-mode bit in the control latch decides when that copy happens. In immediate mode the copy is made at the grayscale write. In deferred mode it is held back until the 65,536th grayscale-clock tick after the grayscale write. After each grayscale write the shift register is reloaded with the per-channel open-LED status, which then shifts out serially. The output enable stays low until the first control write.

All inputs are sampled on one system clock. The serial clock and the grayscale clock enter as single-cycle enables.

Top module: `ser_latch_loader`

## Requirements
- R1: On each cycle with `sclk_en` high and no latch edge, `sin` enters bit 0 of the 769-bit shift register and every bit moves up one place. `sout` always shows bit 768.
- R2: On a rising edge of `lat` with bit 768 equal to 1, bits 370:0 go into the control latch. The grayscale latch, the dot-correction latch and the shift register keep their values.
- R3: On a rising edge of `lat` with bit 768 equal to 0, bits 767:0 go into the grayscale latch, with channel n in bits 16n+15:16n. The control latch keeps its value.
- R4: The control latch layout is: dot correction 335:0, maximum current 344:336, brightness 365:345, function 370:366. The refresh-mode bit is bit 370. With this bit at 0, a grayscale write copies control bits 335:0 into the dot-correction latch on the same edge.
- R5: With the refresh-mode bit at 1, a grayscale write leaves the dot-correction latch unchanged. The copy happens on the 65,536th `gsclk_en` tick after that write, and the 65,535 ticks before it change nothing.
- R6: Once a deferred copy has happened, further grayscale ticks copy nothing until the next grayscale write, even if the control latch changes.
- R7: A grayscale write loads the shift register with 0 in bit 768, `lod[47:0]` in bits 767:720 and zeros below. `sout` is therefore 0 right after the write, then shows `lod[47]` down to `lod[0]` on the following shifts.
- R8: Reset clears all latches, including the maximum-current field, and holds `out_en` low. `out_en` rises at the first control write and stays high.
- R9: Only a rising edge of `lat` writes. Holding `lat` high while a new frame is shifted in writes nothing.
- R10: In a cycle that carries a latch edge, `sclk_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_en | input | 1 | Serial shift enable, one bit per cycle |
| sin | input | 1 | Serial data in |
| lat | input | 1 | Latch strobe, acts on its rising edge |
| gsclk_en | input | 1 | Grayscale clock tick |
| lod | input | 48 | Per-channel open-LED status |
| sout | output | 1 | Serial data out (shift register bit 768) |
| gs_data | output | 768 | Grayscale latch |
| ctrl_data | output | 371 | Control latch |
| dc_data | output | 336 | Dot-correction working latch |
| out_en | output | 1 | Output enable, high once control data has been written |

## Verification
The hardest condition to reach from the ports is the deferred copy boundary. It needs a control write with the refresh bit set, then a grayscale write, then exactly 65,535 grayscale ticks with the dot-correction latch still unchanged, then one more tick. The stimulus checks the latch at both counts. It then rewrites the control latch and runs another full 65,536-tick window, which shows that the pending copy was consumed. The open-status readback is checked bit by bit through a queue while 48 shifts drain it.

// File: rtl/sll_pkg.sv
package sll_pkg;

    localparam int CH_DEF      = 48;
    localparam int GSB_DEF     = 16;
    localparam int CTRL_W_DEF  = 371;
    localparam int DC_W_DEF    = 336;
    localparam int RFB_DEF     = 370;
    localparam int CNT_W_DEF   = 16;

    typedef enum logic {
        LAT_GS   = 1'b0,
        LAT_CTRL = 1'b1
    } lat_sel_e;

    typedef struct packed {
        logic     fire;
        lat_sel_e sel;
    } lat_evt_t;

    function automatic lat_sel_e sel_from_msb(input logic msb);
        return msb ? LAT_CTRL : LAT_GS;
    endfunction

endpackage

// File: rtl/sll_shift_chain.sv
module sll_shift_chain
    import sll_pkg::*;
#(
    parameter int CH  = CH_DEF,
    parameter int GSB = GSB_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_en,
    input  logic              sin,
    input  logic              lat,
    input  logic [CH-1:0]     lod,
    output logic [CH*GSB:0]   sr,
    output lat_evt_t          evt,
    output logic              sout
);

    localparam int GS_W = CH * GSB;
    localparam int SR_W = GS_W + 1;
    localparam int PAD  = GS_W - CH;

    logic lat_q;
    logic rise;

    assign rise     = lat & ~lat_q;
    assign evt.fire = rise;
    assign evt.sel  = sel_from_msb(sr[SR_W-1]);
    assign sout     = sr[SR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 1'b0;
            sr    <= '0;
        end else begin
            lat_q <= lat;
            if (rise) begin
                if (!sr[SR_W-1]) begin
                    sr <= {1'b0, lod, {PAD{1'b0}}};
                end
            end else if (sclk_en) begin
                sr <= {sr[SR_W-2:0], sin};
            end
        end
    end

    // R1: serial advance
    a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
        (sclk_en && !rise) |=> (sr[0] == $past(sin)) && (sr[SR_W-1] == $past(sr[SR_W-2])));

    // R7: open-status reload after a grayscale write
    a_r7_lod_load: assert property (@(posedge clk) disable iff (rst)
        (rise && !sr[SR_W-1]) |=> (sr[SR_W-1] == 1'b0) && (sr[SR_W-2 -: CH] == $past(lod)));

    // R10: control write freezes the chain for that cycle
    a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        (rise && sr[SR_W-1]) |=> $stable(sr));

endmodule

// File: rtl/sll_latch_bank.sv
module sll_latch_bank
    import sll_pkg::*;
#(
    parameter int CH     = CH_DEF,
    parameter int GSB    = GSB_DEF,
    parameter int CTRL_W = CTRL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  lat_evt_t          evt,
    input  logic [CH*GSB:0]   sr,
    output logic [CH*GSB-1:0] gs_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              gs_wr,
    output logic              ctrl_wr,
    output logic              ctrl_seen
);

    localparam int GS_W = CH * GSB;

    assign gs_wr   = evt.fire && (evt.sel == LAT_GS);
    assign ctrl_wr = evt.fire && (evt.sel == LAT_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            gs_q      <= '0;
            ctrl_q    <= '0;
            ctrl_seen <= 1'b0;
        end else begin
            if (gs_wr) begin
                gs_q <= sr[GS_W-1:0];
            end
            if (ctrl_wr) begin
                ctrl_q    <= sr[CTRL_W-1:0];
                ctrl_seen <= 1'b1;
            end
        end
    end

    // R2: control write loads the low bits, grayscale untouched
    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_q == $past(sr[CTRL_W-1:0])) && $stable(gs_q));

    // R3: grayscale write leaves control latch alone
    a_r3_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
        gs_wr |=> $stable(ctrl_q));

    // R9: no write without an edge
    a_r9_no_edge: assert property (@(posedge clk) disable iff (rst)
        !evt.fire |=> $stable(gs_q) && $stable(ctrl_q));

endmodule

// File: rtl/sll_dc_refresh.sv
module sll_dc_refresh
    import sll_pkg::*;
#(
    parameter int DC_W  = DC_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gs_wr,
    input  logic            gsclk_en,
    input  logic            defer,
    input  logic [DC_W-1:0] ctrl_dc,
    output logic [DC_W-1:0] dc_q,
    output logic            pending
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic [CNT_W-1:0] gs_cnt;
    logic             last_tick;

    assign last_tick = gsclk_en && (gs_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            gs_cnt  <= '0;
            pending <= 1'b0;
            dc_q    <= '0;
        end else if (gs_wr) begin
            gs_cnt  <= '0;
            pending <= defer;
            if (!defer) begin
                dc_q <= ctrl_dc;
            end
        end else if (gsclk_en) begin
            gs_cnt <= gs_cnt + 1'b1;
            if (pending && last_tick) begin
                dc_q    <= ctrl_dc;
                pending <= 1'b0;
            end
        end
    end

    // R4: immediate copy
    a_r4_copy_now: assert property (@(posedge clk) disable iff (rst)
        (gs_wr && !defer) |=> (dc_q == $past(ctrl_dc)) && !pending);

    // R5: deferred mode arms the copy and holds the latch
    a_r5_defer_arm: assert property (@(posedge clk) disable iff (rst)
        (gs_wr && defer) |=> pending && $stable(dc_q));

    // R6: the copy disarms itself
    a_r6_disarm: assert property (@(posedge clk) disable iff (rst)
        (!gs_wr && pending && last_tick) |=> !pending);

    // R6: idle latch without a write or an armed final tick
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        (!gs_wr && !pending) |=> $stable(dc_q));

endmodule

// File: rtl/ser_latch_loader.sv
module ser_latch_loader
    import sll_pkg::*;
#(
    parameter int CH     = CH_DEF,
    parameter int GSB    = GSB_DEF,
    parameter int CTRL_W = CTRL_W_DEF,
    parameter int DC_W   = DC_W_DEF,
    parameter int RFB    = RFB_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_en,
    input  logic              sin,
    input  logic              lat,
    input  logic              gsclk_en,
    input  logic [CH-1:0]     lod,
    output logic              sout,
    output logic [CH*GSB-1:0] gs_data,
    output logic [CTRL_W-1:0] ctrl_data,
    output logic [DC_W-1:0]   dc_data,
    output logic              out_en
);

    localparam int GS_W = CH * GSB;

    logic [GS_W:0] sr;
    lat_evt_t      evt;
    logic          gs_wr;
    logic          ctrl_wr;
    logic          ctrl_seen;
    logic          pending;

    sll_shift_chain #(.CH(CH), .GSB(GSB)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .sclk_en (sclk_en),
        .sin     (sin),
        .lat     (lat),
        .lod     (lod),
        .sr      (sr),
        .evt     (evt),
        .sout    (sout)
    );

    sll_latch_bank #(.CH(CH), .GSB(GSB), .CTRL_W(CTRL_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sr        (sr),
        .gs_q      (gs_data),
        .ctrl_q    (ctrl_data),
        .gs_wr     (gs_wr),
        .ctrl_wr   (ctrl_wr),
        .ctrl_seen (ctrl_seen)
    );

    sll_dc_refresh #(.DC_W(DC_W), .CNT_W(CNT_W)) u_dc (
        .clk      (clk),
        .rst      (rst),
        .gs_wr    (gs_wr),
        .gsclk_en (gsclk_en),
        .defer    (ctrl_data[RFB]),
        .ctrl_dc  (ctrl_data[DC_W-1:0]),
        .dc_q     (dc_data),
        .pending  (pending)
    );

    assign out_en = ctrl_seen;

    // R8: enable only follows a control write and never drops
    a_r8_en_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> $past(ctrl_wr));

    a_r8_en_sticky: assert property (@(posedge clk) disable iff (rst)
        out_en |=> out_en);

endmodule

// File: tb/sim_ser_latch_loader.sv
`timescale 1ns/1ps
module sim_ser_latch_loader;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_en = 1'b0;
    logic         sin = 1'b0;
    logic         lat = 1'b0;
    logic         gsclk_en = 1'b0;
    logic [47:0]  lod = '0;
    logic         sout;
    logic [767:0] gs_data;
    logic [370:0] ctrl_data;
    logic [335:0] dc_data;
    logic         out_en;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    logic exp_q[$];

    always #2 clk = ~clk;

    ser_latch_loader u0 (
        .clk(clk), .rst(rst), .sclk_en(sclk_en), .sin(sin), .lat(lat),
        .gsclk_en(gsclk_en), .lod(lod), .sout(sout), .gs_data(gs_data),
        .ctrl_data(ctrl_data), .dc_data(dc_data), .out_en(out_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [1023:0] act, input logic [1023:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops the expected serial stream (R7)
    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            if (exp_q.size() == 0) begin
                chk("R7", "stream underrun", 1'b1, 1'b0);
            end else begin
                chk("R7", "sout stream", sout, exp_q.pop_front());
            end
        end
    end

    function automatic logic [768:0] ctrl_frame(input logic [31:0] seed, input logic defer);
        logic [383:0] r;
        logic [370:0] c;
        r = {12{seed}};
        c = r[370:0];
        c[370] = defer;
        c[335] = 1'b0;
        return {1'b1, 397'b0, c};
    endfunction

    function automatic logic [768:0] gs_frame(input logic [31:0] seed);
        return {1'b0, {24{seed}}};
    endfunction

    task automatic send(input logic [768:0] f, input bit shift_on_lat, input bit hold);
        for (int i = 768; i >= 0; i--) begin
            @(negedge clk);
            sclk_en = 1'b1;
            sin     = f[i];
        end
        @(negedge clk);
        sclk_en = shift_on_lat;
        sin     = 1'b1;
        lat     = 1'b1;
        @(negedge clk);
        sclk_en = 1'b0;
        lat     = hold;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gsclk_en = 1'b1;
        end
        @(negedge clk);
        gsclk_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [768:0] fa, fb, fc, g1, g2, g3;
        fa = ctrl_frame(32'h1234_5678, 1'b0);
        fb = ctrl_frame(32'hC0DE_F00D, 1'b1);
        fc = ctrl_frame(32'h0F1E_2D3C, 1'b1);
        g1 = gs_frame(32'hDEAD_BEEF);
        g2 = gs_frame(32'h0BAD_CAFE);
        g3 = gs_frame(32'h5555_AAAA);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk("R8", "out_en after reset", out_en, 1'b0);
        chk("R8", "ctrl after reset", ctrl_data, '0);
        chk("R8", "gs after reset", gs_data, '0);
        chk("R8", "dc after reset", dc_data, '0);
        chk("R1", "sout after reset", sout, 1'b0);

        // control write, immediate mode, shift requested on the latch cycle
        send(fa, 1'b1, 1'b0);
        chk("R2", "ctrl load", ctrl_data, fa[370:0]);
        chk("R2", "gs untouched", gs_data, '0);
        chk("R2", "dc untouched", dc_data, '0);
        chk("R8", "out_en after ctrl", out_en, 1'b1);
        chk("R10", "sout keeps msb", sout, 1'b1);

        // grayscale write, immediate copy
        lod = 48'hA5C3_0F96_3C81;
        send(g1, 1'b0, 1'b0);
        chk("R3", "gs load", gs_data, g1[767:0]);
        chk("R3", "channel 0", gs_data[15:0], g1[15:0]);
        chk("R3", "ctrl kept", ctrl_data, fa[370:0]);
        chk("R4", "dc immediate", dc_data, fa[335:0]);
        chk("R7", "sout low after gs", sout, 1'b0);
        // R7 open-status readback through the scoreboard
        for (int k = 47; k >= 0; k--) exp_q.push_back(lod[k]);
        @(negedge clk);
        mon_en  = 1'b1;
        sclk_en = 1'b1;
        sin     = 1'b0;
        repeat (47) @(negedge clk);
        @(negedge clk);
        sclk_en = 1'b0;
        mon_en  = 1'b0;
        chk("R7", "stream drained", exp_q.size(), 0);

        // deferred mode
        send(fb, 1'b0, 1'b0);
        chk("R4", "dc not copied on ctrl write", dc_data, fa[335:0]);
        chk("R8", "out_en sticky", out_en, 1'b1);
        send(g2, 1'b0, 1'b1);
        chk("R3", "gs second load", gs_data, g2[767:0]);
        chk("R5", "dc held at deferred gs write", dc_data, fa[335:0]);
        // lat stays high across a whole new frame
        send(g3, 1'b0, 1'b1);
        chk("R9", "no write without edge", gs_data, g2[767:0]);
        @(negedge clk);
        lat = 1'b0;

        ticks(65535);
        chk("R5", "dc held at tick 65535", dc_data, fa[335:0]);
        ticks(1);
        chk("R5", "dc copied at tick 65536", dc_data, fb[335:0]);

        send(fc, 1'b0, 1'b0);
        ticks(65536);
        chk("R6", "no second copy", dc_data, fb[335:0]);
        chk("R2", "ctrl third load", ctrl_data, fc[370:0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule